// File: doc/BRIEF.md
# Next Program Counter Unit with Branch, Jump and Call Support

This block holds the program counter of a simple 32-bit core and works out, every cycle, which address comes next. Each cycle it takes the instruction word that sits at the current PC and the two operand values read from its first and second source register fields. From these it picks one of four next addresses: the sequential address, a PC-relative branch target, a region-absolute jump target, or a target taken from a register. The chosen address is loaded into the PC register on the next rising clock edge.

It resolves two conditional branches: branch-if-equal and branch-if-not-equal. It also resolves three unconditional transfers: a plain jump, a call that jumps and links, and a jump through a register that is used for returns and computed jumps. For a call, the unit also drives a register-file write request. The request carries the address of the instruction after the call and the fixed return-address register index 31. Fetch, the register file and any delay-slot handling are left to the surrounding core.

Top module: `npc_unit`

## Requirements
- R1: While `rst` is high at a rising edge, `pc_o` is loaded with the parameter `RESET_PC` (default 0x0000_1000), and it keeps that value in the first cycle after `rst` falls.
- R2: An instruction that is not a control transfer makes `npc_o` equal `pc_o + 4`. `pc_o` takes that value at the next rising edge.
- R3: Opcode 4 (bits 31:26) with `rs_val_i == rt_val_i` gives a branch target of `pc_o + 4` plus bits 15:0 sign-extended and multiplied by 4.
- R4: Opcode 4 with `rs_val_i != rt_val_i` gives `pc_o + 4`.
- R5: Opcode 5 with `rs_val_i != rt_val_i` gives the branch target defined in R3.
- R6: Opcode 5 with `rs_val_i == rt_val_i` gives `pc_o + 4`.
- R7: Opcode 2 gives the jump target. This is bits 31:28 of `pc_o + 4`, then bits 25:0 of the instruction, then two zero bits. The top bits come from `pc_o + 4`, not from `pc_o`.
- R8: Opcode 3 gives the same jump target as R7. In that cycle it also sets `link_we_o` = 1, `link_idx_o` = 31 and `link_data_o` = `pc_o + 4`.
- R9: Opcode 0 with function field (bits 5:0) equal to 8 makes `npc_o` equal `rs_val_i`.
- R10: `link_we_o` is 0 for every instruction except opcode 3, including the register jump of R9.
- R11: Opcode 0 with any function field other than 8 is sequential, as in R2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| instr_i | input | 32 | Instruction word located at `pc_o` |
| rs_val_i | input | 32 | Value read from the first source register |
| rt_val_i | input | 32 | Value read from the second source register |
| pc_o | output | 32 | Current program counter |
| npc_o | output | 32 | Next program counter (combinational) |
| link_we_o | output | 1 | Return-address write request, high only for a call |
| link_idx_o | output | 5 | Destination register index of the link write (31) |
| link_data_o | output | 32 | Return address written on a call |

## Verification
The only state in the block is the PC register. A wrong decode or a bad target calculation therefore shows up on `npc_o` in the same cycle and on `pc_o` one edge later. From then on, every following sequential step is offset, so one wrong redirection never goes away and is caught at the next compare. A reference model in the bench tracks the PC independently and compares `npc_o` and the link outputs just after the inputs settle, and `pc_o` after every edge. The stimulus covers forward and backward branch offsets, the most negative offset, and a jump whose upper address bits come from a `pc_o + 4` that crosses a 256 MB region boundary.

// File: rtl/npc_pkg.sv
package npc_pkg;

    localparam int XLEN      = 32;
    localparam int REG_IDX_W = 5;
    localparam int OFF_W     = 16;
    localparam int IDX_W     = 26;
    localparam int REGION_W  = XLEN - IDX_W - 2;
    localparam int OP_W      = 6;
    localparam int FN_W      = 6;

    localparam logic [OP_W-1:0] OPC_SPECIAL = 6'd0;
    localparam logic [OP_W-1:0] OPC_JUMP    = 6'd2;
    localparam logic [OP_W-1:0] OPC_CALL    = 6'd3;
    localparam logic [OP_W-1:0] OPC_BR_EQ   = 6'd4;
    localparam logic [OP_W-1:0] OPC_BR_NE   = 6'd5;
    localparam logic [FN_W-1:0] FN_REGJUMP  = 6'd8;

    localparam logic [REG_IDX_W-1:0] RA_INDEX = 5'd31;
    localparam logic [XLEN-1:0]      STEP     = 32'd4;

    typedef enum logic [2:0] {
        FLOW_SEQ,
        FLOW_BR_EQ,
        FLOW_BR_NE,
        FLOW_JUMP,
        FLOW_CALL,
        FLOW_REG
    } flow_e;

    typedef struct packed {
        flow_e             flow;
        logic [OFF_W-1:0]  offset;
        logic [IDX_W-1:0]  index;
        logic              link;
    } flow_ctl_t;

    typedef struct packed {
        logic [XLEN-1:0] seq;
        logic [XLEN-1:0] branch;
        logic [XLEN-1:0] jump;
    } targets_t;

    function automatic logic [XLEN-1:0] scaled_offset(input logic [OFF_W-1:0] off);
        return {{(XLEN-OFF_W-2){off[OFF_W-1]}}, off, 2'b00};
    endfunction

    function automatic logic [XLEN-1:0] region_target(input logic [XLEN-1:0] seq_pc,
                                                      input logic [IDX_W-1:0] idx);
        return {seq_pc[XLEN-1 -: REGION_W], idx, 2'b00};
    endfunction

endpackage

// File: rtl/npc_decode.sv
module npc_decode
    import npc_pkg::*;
(
    input  logic [XLEN-1:0] instr_i,
    output flow_ctl_t       ctl_o
);
    logic [OP_W-1:0] opc;
    logic [FN_W-1:0] fn;

    assign opc = instr_i[XLEN-1 -: OP_W];
    assign fn  = instr_i[FN_W-1:0];

    always_comb begin
        ctl_o.offset = instr_i[OFF_W-1:0];
        ctl_o.index  = instr_i[IDX_W-1:0];
        ctl_o.link   = 1'b0;
        ctl_o.flow   = FLOW_SEQ;
        unique case (opc)
            OPC_BR_EQ: ctl_o.flow = FLOW_BR_EQ;
            OPC_BR_NE: ctl_o.flow = FLOW_BR_NE;
            OPC_JUMP:  ctl_o.flow = FLOW_JUMP;
            OPC_CALL: begin
                ctl_o.flow = FLOW_CALL;
                ctl_o.link = 1'b1;
            end
            OPC_SPECIAL: begin
                if (fn == FN_REGJUMP) ctl_o.flow = FLOW_REG;
            end
            default: ctl_o.flow = FLOW_SEQ;
        endcase
    end

    // R10: a link request only ever comes with the call flow
    always_comb begin
        if (ctl_o.link) begin
            a_link_call_r10: assert (ctl_o.flow == FLOW_CALL);
        end
    end
endmodule

// File: rtl/npc_target.sv
module npc_target
    import npc_pkg::*;
(
    input  logic [XLEN-1:0]  pc_i,
    input  logic [OFF_W-1:0] offset_i,
    input  logic [IDX_W-1:0] index_i,
    output targets_t         tgt_o
);
    logic [XLEN-1:0] seq_pc;

    assign seq_pc        = pc_i + STEP;
    assign tgt_o.seq     = seq_pc;
    assign tgt_o.branch  = seq_pc + scaled_offset(offset_i);
    assign tgt_o.jump    = region_target(seq_pc, index_i);
endmodule

// File: rtl/npc_select.sv
module npc_select
    import npc_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  flow_e           flow_i,
    input  targets_t        tgt_i,
    input  logic [XLEN-1:0] rs_val_i,
    input  logic [XLEN-1:0] rt_val_i,
    output logic [XLEN-1:0] npc_o
);
    logic same;

    assign same = (rs_val_i == rt_val_i);

    always_comb begin
        unique case (flow_i)
            FLOW_BR_EQ: npc_o = same  ? tgt_i.branch : tgt_i.seq;
            FLOW_BR_NE: npc_o = !same ? tgt_i.branch : tgt_i.seq;
            FLOW_JUMP,
            FLOW_CALL:  npc_o = tgt_i.jump;
            FLOW_REG:   npc_o = rs_val_i;
            default:    npc_o = tgt_i.seq;
        endcase
    end

    p_beq_taken_r3: assert property (@(posedge clk) disable iff (rst)
        (flow_i == FLOW_BR_EQ && rs_val_i == rt_val_i) |-> npc_o == tgt_i.branch);
    p_beq_fall_r4: assert property (@(posedge clk) disable iff (rst)
        (flow_i == FLOW_BR_EQ && rs_val_i != rt_val_i) |-> npc_o == tgt_i.seq);
    p_bne_taken_r5: assert property (@(posedge clk) disable iff (rst)
        (flow_i == FLOW_BR_NE && rs_val_i != rt_val_i) |-> npc_o == tgt_i.branch);
    p_bne_fall_r6: assert property (@(posedge clk) disable iff (rst)
        (flow_i == FLOW_BR_NE && rs_val_i == rt_val_i) |-> npc_o == tgt_i.seq);
endmodule

// File: rtl/npc_unit.sv
module npc_unit
    import npc_pkg::*;
#(
    parameter logic [31:0] RESET_PC = 32'h0000_1000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [31:0] instr_i,
    input  logic [31:0] rs_val_i,
    input  logic [31:0] rt_val_i,
    output logic [31:0] pc_o,
    output logic [31:0] npc_o,
    output logic        link_we_o,
    output logic [4:0]  link_idx_o,
    output logic [31:0] link_data_o
);
    flow_ctl_t       ctl;
    targets_t        tgt;
    logic [XLEN-1:0] pc_q;
    logic [XLEN-1:0] npc;

    npc_decode u_decode (
        .instr_i (instr_i),
        .ctl_o   (ctl)
    );

    npc_target u_target (
        .pc_i     (pc_q),
        .offset_i (ctl.offset),
        .index_i  (ctl.index),
        .tgt_o    (tgt)
    );

    npc_select u_select (
        .clk      (clk),
        .rst      (rst),
        .flow_i   (ctl.flow),
        .tgt_i    (tgt),
        .rs_val_i (rs_val_i),
        .rt_val_i (rt_val_i),
        .npc_o    (npc)
    );

    always_ff @(posedge clk) begin
        if (rst) pc_q <= RESET_PC;
        else     pc_q <= npc;
    end

    assign pc_o        = pc_q;
    assign npc_o       = npc;
    assign link_we_o   = ctl.link;
    assign link_idx_o  = RA_INDEX;
    assign link_data_o = tgt.seq;

    p_reset_pc_r1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> pc_q == RESET_PC);
    p_seq_step_r2: assert property (@(posedge clk) disable iff (rst)
        (ctl.flow == FLOW_SEQ) |=> pc_q == $past(pc_q) + STEP);
    p_jump_region_r7: assert property (@(posedge clk) disable iff (rst)
        (ctl.flow == FLOW_JUMP) |=> pc_q[1:0] == 2'b00);
    p_call_link_r8: assert property (@(posedge clk) disable iff (rst)
        link_we_o |-> (link_idx_o == 5'd31 && link_data_o == pc_q + STEP));
    p_regjump_r9: assert property (@(posedge clk) disable iff (rst)
        (ctl.flow == FLOW_REG) |=> pc_q == $past(rs_val_i));
    p_no_link_r10: assert property (@(posedge clk) disable iff (rst)
        (ctl.flow != FLOW_CALL) |-> !link_we_o);
endmodule

// File: tb/npc_unit_tb.sv
module npc_unit_tb;
    localparam int PERIOD = 10;
    localparam logic [31:0] RST_PC = 32'h0000_1000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [31:0] instr = 32'h0;
    logic [31:0] rs_v = 32'h0;
    logic [31:0] rt_v = 32'h0;
    logic [31:0] pc, npc, ldata;
    logic        lwe;
    logic [4:0]  lidx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;
    logic [31:0] model_pc;

    always #(PERIOD/2) clk = ~clk;

    npc_unit #(.RESET_PC(RST_PC)) u_dut (
        .clk(clk), .rst(rst), .instr_i(instr), .rs_val_i(rs_v), .rt_val_i(rt_v),
        .pc_o(pc), .npc_o(npc), .link_we_o(lwe), .link_idx_o(lidx), .link_data_o(ldata)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] enc_i(int op, int rs, int rt, logic [15:0] imm);
        logic [5:0] o = 6'(op);
        logic [4:0] s = 5'(rs);
        logic [4:0] t = 5'(rt);
        return {o, s, t, imm};
    endfunction

    function automatic logic [31:0] enc_j(int op, logic [25:0] idx);
        logic [5:0] o = 6'(op);
        return {o, idx};
    endfunction

    function automatic logic [31:0] enc_r(int rs, int fn);
        logic [4:0] s = 5'(rs);
        logic [5:0] f = 6'(fn);
        return {6'd0, s, 15'd0, f};
    endfunction

    // Behavioural expectation straight from the requirements
    task automatic step(input string req, input logic [31:0] ins,
                        input logic [31:0] a, input logic [31:0] b);
        logic [31:0] p4, exp;
        logic [31:0] boff;
        int op;
        bit call;
        p4   = model_pc + 32'd4;
        boff = 32'($signed(ins[15:0])) * 4;
        op   = int'(ins[31:26]);
        call = (op == 3);
        exp  = p4;
        if (op == 4 && a == b) exp = p4 + boff;
        if (op == 5 && a != b) exp = p4 + boff;
        if (op == 2 || op == 3) exp = {p4[31:28], ins[25:0], 2'b00};
        if (op == 0 && ins[5:0] == 6'd8) exp = a;
        instr = ins; rs_v = a; rt_v = b;
        #1;
        chk({req, " npc"}, npc, exp);
        chk("R10 link_we", {31'd0, lwe}, {31'd0, call});
        if (call) begin
            chk("R8 link_idx", {27'd0, lidx}, 32'd31);
            chk("R8 link_data", ldata, p4);
        end
        @(negedge clk);
        model_pc = exp;
        chk({req, " pc"}, pc, model_pc);
    endtask

    initial begin
        #(PERIOD * 5000);
        if (!done) begin
            fails++;
            checks++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (2) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        model_pc = RST_PC;
        chk("R1 reset pc", pc, RST_PC);

        step("R11 add", 32'h0232_4020, 32'd7, 32'd9);
        step("R2 load", 32'h8E68_0020, 32'd1, 32'd1);
        step("R3 beq fwd", enc_i(4, 8, 9, 16'd3), 32'd5, 32'd5);
        step("R4 beq ne", enc_i(4, 8, 9, 16'd3), 32'd1, 32'd2);
        step("R5 bne back", enc_i(5, 8, 9, 16'hFFFE), 32'd3, 32'd4);
        step("R6 bne eq", enc_i(5, 8, 9, 16'hFFFE), 32'hA5A5_0000, 32'hA5A5_0000);
        step("R7 jump", enc_j(2, 26'h000_0800), 32'd0, 32'd0);
        step("R8 call", enc_j(3, 26'h000_0400), 32'd0, 32'd0);
        step("R9 regjump", enc_r(31, 8), 32'h1FFF_FFFC, 32'd0);
        step("R7 region cross", enc_j(2, 26'h000_0010), 32'd0, 32'd0);
        step("R11 funct9", enc_r(4, 9), 32'h0000_4000, 32'd0);
        step("R3 beq min off", enc_i(4, 1, 1, 16'h8000), 32'd0, 32'd0);
        step("R8 call high", enc_j(3, 26'h3FF_FFFF), 32'd0, 32'd0);
        step("R10 regjump nolink", enc_r(31, 8), 32'h0000_2000, 32'd0);
        step("R5 bne fwd", enc_i(5, 2, 3, 16'h0010), 32'd0, 32'd1);
        step("R2 addi", enc_i(8, 1, 2, 16'h0005), 32'd0, 32'd0);

        rst = 1'b1;
        @(negedge clk);
        rst = 1'b0;
        model_pc = RST_PC;
        chk("R1 reset midrun", pc, RST_PC);
        step("R2 after reset", 32'h0000_0000, 32'd0, 32'd0);

        done = 1'b1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
        $finish;
    end
endmodule